// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a three-wire serial audio stream (a bit clock, a word-select line that serves as a frame sync in time-division mode, and a data line) and turns it into parallel left and right samples. One shift engine covers four framings: I2S, left-justified, right-justified and a time-division multiplexed (TDM) mode. It also covers four sample widths: 16, 20, 24 and 32 bits. Each sample is sign-extended to a 32-bit word.

The block runs on the bit clock itself and samples the data and word-select lines on its rising edge. Framing format, sample width and the two TDM slot indices are static configuration inputs. They are changed only while reset is held. Once per frame, after the right sample has been taken, the block raises a valid strobe for one bit-clock cycle.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after its release, `left_out` and `right_out` are zero and `valid` is low until the first sample has been captured.
- R2: With `fmt` = 1 (left-justified), data is MSB first and the MSB is sampled on the same bit clock where `ws` is first seen at its new level. `ws` high carries the left channel.
- R3: With `fmt` = 0 (I2S), data is MSB first and the MSB is sampled one bit clock after the bit clock where `ws` is first seen at its new level. `ws` low carries the left channel.
- R4: With `fmt` = 2 (right-justified), the sample is the last N bits received before `ws` changes level, so earlier bits of the half-frame are ignored. `ws` high carries the left channel.
- R5: With `fmt` = 3 (TDM), `ws` high for one bit clock marks the start of a frame. Bit 0 of slot 0 is sampled on the next bit clock. Each slot is 32 bit clocks long, and its sample occupies the first N bits, MSB first. The slots named by `slot_left` and `slot_right` feed `left_out` and `right_out`, and all other slots are ignored.
- R6: `width_sel` picks N: 0 for 16 bits, 1 for 20, 2 for 24 and 3 for 32. The N-bit sample is sign-extended to 32 bits, and bits of the half-frame or slot outside those N are ignored.
- R7: `valid` is high for exactly one bit clock, in the cycle where `right_out` takes a new sample. That happens once per frame. `right_out` changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock; everything samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws | input | 1 | Word select, or frame sync pulse in TDM mode |
| sd | input | 1 | Serial data line |
| fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 TDM |
| width_sel | input | 2 | Sample width: 0 16, 1 20, 2 24, 3 32 bits |
| slot_left | input | SLOT_W | TDM slot index taken as the left sample |
| slot_right | input | SLOT_W | TDM slot index taken as the right sample |
| left_out | output | 32 | Sign-extended left sample |
| right_out | output | 32 | Sign-extended right sample |
| valid | output | 1 | One-cycle strobe after the right sample of a frame |

## Verification
The assertions assume that `width_sel` stays unchanged outside reset. They also assume every frame is at least a few bit clocks long, so that two right-sample captures never fall in adjacent cycles. Each directed case sets its configuration only while reset is held. It then sends complete, periodic frames: 16 or 32 bit clocks per half, or four 32-bit TDM slots. Those frames always give each capture a full half-frame or frame of spacing. Bit positions outside the sample are filled with a changing junk pattern, so that a sample taken from the wrong position shows up at the outputs.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int MAX_SLOTS = 8,
  localparam int WORD_W = 32,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int SLOT_W = $clog2(MAX_SLOTS),
  localparam int POS_W = SLOT_W + BIT_W + 1
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              ws,
  input  logic              sd,
  input  logic [1:0]        fmt,
  input  logic [1:0]        width_sel,
  input  logic [SLOT_W-1:0] slot_left,
  input  logic [SLOT_W-1:0] slot_right,
  output logic [WORD_W-1:0] left_out,
  output logic [WORD_W-1:0] right_out,
  output logic              valid
);

  localparam logic [1:0] FMT_I2S = 2'd0;
  localparam logic [1:0] FMT_LJ  = 2'd1;
  localparam logic [1:0] FMT_RJ  = 2'd2;
  localparam logic [1:0] FMT_TDM = 2'd3;
  localparam logic [POS_W-1:0] POS_IDLE = '1;

  logic              ws_d, seen;
  logic [WORD_W-1:0] sr;
  logic [POS_W-1:0]  pos, idx, pos_nx;
  logic [BIT_W-1:0]  lastbit;
  logic              cap_l, cap_r;

  wire              ws_edge = seen && (ws != ws_d);
  wire [WORD_W-1:0] sr_nx   = {sr[WORD_W-2:0], sd};
  wire [WORD_W-1:0] raw     = (fmt == FMT_RJ) ? sr : sr_nx;
  wire              hit_std = (idx == {{(SLOT_W+1){1'b0}}, lastbit});
  wire              hit_l   = (idx == {1'b0, slot_left, lastbit});
  wire              hit_r   = (idx == {1'b0, slot_right, lastbit});

  function automatic logic [WORD_W-1:0] sext(input logic [WORD_W-1:0] r, input logic [1:0] w);
    case (w)
      2'd0:    sext = {{16{r[15]}}, r[15:0]};
      2'd1:    sext = {{12{r[19]}}, r[19:0]};
      2'd2:    sext = {{8{r[23]}},  r[23:0]};
      default: sext = r;
    endcase
  endfunction

  always_comb begin
    case (width_sel)
      2'd0:    lastbit = BIT_W'(15);
      2'd1:    lastbit = BIT_W'(19);
      2'd2:    lastbit = BIT_W'(23);
      default: lastbit = BIT_W'(31);
    endcase
  end

  always_comb begin
    idx = (fmt == FMT_LJ && ws_edge) ? '0 : pos;
    if ((fmt == FMT_I2S && ws_edge) || (fmt == FMT_TDM && ws))
      pos_nx = '0;
    else if (idx != POS_IDLE)
      pos_nx = idx + 1'b1;
    else
      pos_nx = idx;
  end

  always_comb begin
    case (fmt)
      FMT_I2S: begin cap_l = hit_std && !ws_d; cap_r = hit_std && ws_d; end
      FMT_LJ:  begin cap_l = hit_std && ws;    cap_r = hit_std && !ws;  end
      FMT_RJ:  begin cap_l = ws_edge && ws_d;  cap_r = ws_edge && !ws_d; end
      default: begin cap_l = hit_l;            cap_r = hit_r;           end
    endcase
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      ws_d      <= 1'b0;
      seen      <= 1'b0;
      sr        <= '0;
      pos       <= POS_IDLE;
      left_out  <= '0;
      right_out <= '0;
      valid     <= 1'b0;
    end else begin
      ws_d  <= ws;
      seen  <= 1'b1;
      sr    <= sr_nx;
      pos   <= pos_nx;
      valid <= cap_r;
      if (cap_l) left_out  <= sext(raw, width_sel);
      if (cap_r) right_out <= sext(raw, width_sel);
    end
  end

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk (
  input logic        sclk,
  input logic        rst_n,
  input logic [1:0]  width_sel,
  input logic [31:0] left_out,
  input logic [31:0] right_out,
  input logic        valid
);

  // R7
  valid_single_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    valid |=> !valid);

  // R7
  right_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !valid |-> $stable(right_out));

  // R6
  left_sext16_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (width_sel == 2'd0) |-> (left_out[31:15] == '0 || left_out[31:15] == '1));

  // R6
  right_sext20_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (width_sel == 2'd1) |-> (right_out[31:19] == '0 || right_out[31:19] == '1));

  // R1
  reset_quiet_chk: assert property (@(posedge sclk)
    !rst_n |-> (!valid && left_out == '0 && right_out == '0));

endmodule

bind serial_audio_rx serial_audio_rx_chk u_chk (
  .sclk(sclk), .rst_n(rst_n), .width_sel(width_sel),
  .left_out(left_out), .right_out(right_out), .valid(valid)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ws = 1'b0;
  logic        sd = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [1:0]  width_sel = 2'd0;
  logic [2:0]  slot_left = 3'd0;
  logic [2:0]  slot_right = 3'd1;
  logic [31:0] left_out, right_out;
  logic        valid;
  int checks = 0;
  int failures = 0;

  always #5 sclk = ~sclk;

  serial_audio_rx u_dut (
    .sclk(sclk), .rst_n(rst_n), .ws(ws), .sd(sd), .fmt(fmt),
    .width_sel(width_sel), .slot_left(slot_left), .slot_right(slot_right),
    .left_out(left_out), .right_out(right_out), .valid(valid)
  );

  function automatic logic [31:0] sx(input logic [31:0] v, input int n);
    logic [31:0] r;
    r = v;
    for (int i = n; i < 32; i++) r[i] = v[n-1];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic test_reset();
    int vc;
    vc = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge sclk);
    chk(left_out == 0 && right_out == 0, "R1 outputs in reset", left_out | right_out, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge sclk);
      if (valid) vc++;
    end
    chk(vc == 0, "R1 no valid without frames", vc, 0);
    chk(left_out == 0 && right_out == 0, "R1 outputs after release", left_out | right_out, 0);
  endtask

  task automatic run_case(input string tag, input logic [1:0] f, input logic [1:0] w, input int half,
                          input logic [31:0] lv, input logic [31:0] rv, input int sl, input int sr_i);
    logic sdv[256];
    logic wsv[256];
    int n, fl, vc, p;
    logic lft;
    logic [31:0] d;
    n  = (w == 0) ? 16 : (w == 1) ? 20 : (w == 2) ? 24 : 32;
    fl = (f == 3) ? 128 : 2 * half;
    for (int j = 0; j < 256; j++) begin
      sdv[j] = j[0] ^ j[1] ^ j[3];
      wsv[j] = 1'b0;
    end
    if (f == 3) begin
      for (int s = 0; s < 4; s++) begin
        d = (s == sl) ? lv : (s == sr_i) ? rv : (32'h5A3C_96E1 ^ (s * 32'h1111_1111));
        for (int k = 0; k < n; k++) sdv[s*32+k] = d[n-1-k];
      end
      wsv[fl-1] = 1'b1;
    end else begin
      lft = (f == 0) ? 1'b0 : 1'b1;
      for (int c = 0; c < 2; c++) begin
        d = (c == 0) ? lv : rv;
        for (int j = 0; j < half; j++) wsv[c*half+j] = (c == 0) ? lft : ~lft;
        for (int k = 0; k < n; k++) begin
          if (f == 0)      p = (c*half + 1 + k) % fl;
          else if (f == 1) p = c*half + k;
          else             p = c*half + half - n + k;
          sdv[p] = d[n-1-k];
        end
      end
    end
    @(negedge sclk);
    rst_n = 1'b0;
    fmt = f;
    width_sel = w;
    slot_left = 3'(sl);
    slot_right = 3'(sr_i);
    ws = wsv[fl-1];
    sd = 1'b0;
    repeat (2) @(negedge sclk);
    rst_n = 1'b1;
    vc = 0;
    for (int fr = 0; fr < 4; fr++) begin
      for (int j = 0; j < fl; j++) begin
        if (j != 0 || fr != 0) @(negedge sclk);
        if (fr >= 2 && valid) vc++;
        ws = wsv[j];
        sd = sdv[j];
      end
    end
    @(negedge sclk);
    chk(left_out == sx(lv, n), {tag, " left"}, left_out, sx(lv, n));
    chk(right_out == sx(rv, n), {tag, " right"}, right_out, sx(rv, n));
    chk(vc == 2, {tag, " R7 one valid per frame"}, vc, 2);
  endtask

  initial begin
    test_reset();
    run_case("R2 LJ 24b in 32", 2'd1, 2'd2, 32, 32'h008A_1234, 32'h003B_CDEF, 0, 1);
    run_case("R2 LJ 16b in 16", 2'd1, 2'd0, 16, 32'h0000_7F01, 32'h0000_80FE, 0, 1);
    run_case("R3 I2S 32b in 32", 2'd0, 2'd3, 32, 32'hC001_D00D, 32'h1234_5678, 0, 1);
    run_case("R3 I2S 16b in 16", 2'd0, 2'd0, 16, 32'h0000_9ABC, 32'h0000_2468, 0, 1);
    run_case("R4 R6 RJ 20b in 32", 2'd2, 2'd1, 32, 32'h000F_0F0F, 32'h0008_1234, 0, 1);
    run_case("R4 RJ 16b in 16", 2'd2, 2'd0, 16, 32'h0000_A55A, 32'h0000_0F0F, 0, 1);
    run_case("R5 R6 TDM 24b slots 2,1", 2'd3, 2'd2, 32, 32'h00F0_0001, 32'h0070_00FF, 2, 1);
    run_case("R5 TDM 32b slots 0,3", 2'd3, 2'd3, 32, 32'h8765_4321, 32'h0BAD_F00D, 0, 3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule